// File: doc/BRIEF.md
# Multiplexed External Address Phase Generator

This block drives the address phase of an external memory cycle for a controller with a narrow data bus. A request presents a byte address and a bus-width mode. The block then issues a one-clock, active-low latch strobe. During that clock, a 6-bit dedicated address bus carries the upper address bits and a 16-bit shared address/data bus carries the middle address bits. An external latch captures both, either on the strobe edge itself or on a clock rising edge while the strobe is low.

A global configuration bit adds one hold clock after the strobe. During the hold clock, the latched values stay on the pins. The bit resets to 1. When the address phase ends, a one-clock done pulse shows that the data phase may begin. From then on the dedicated bus carries the lowest address bits. Later burst beats reload only the address register, so the dedicated bus shows the new lowest bits and no new strobe is issued. A busy output covers the strobe and hold clocks. Requests that arrive while busy is high are dropped.

The mode sets the bit mapping. In 16-bit mode the usable space is 512 MB, and in 8-bit mode it is 256 MB. The mode and the address are captured together when a request or a beat is accepted.

Top module: `addr_phase_gen`

## Requirements
- R1: After synchronous reset, ace_n_o is 1, busy_o is 0, done_o is 0, sa_o is 0 and sadb_o is 0. The hold configuration resets to 1, so the first address phase after reset includes a hold clock.
- R2: If start_i is high in a clock where busy_o is low, then in the next clock ace_n_o is 0 and busy_o is 1. ace_n_o is low for exactly one clock per accepted request.
- R3: With wide_i=1 (16-bit mode) captured at start, sa_o equals addr[28:23] and sadb_o equals addr[22:7] during the strobe clock. Outside the address phase, sa_o equals addr[6:1].
- R4: With wide_i=0 (8-bit mode) captured at start, sa_o equals addr[27:22] and sadb_o equals addr[21:6] during the strobe clock. Outside the address phase, sa_o equals addr[5:0].
- R5: With the hold configuration at 1, the clock after the strobe has ace_n_o=1, busy_o=1 and done_o=0, and sa_o and sadb_o keep their strobe-clock values. done_o pulses in the clock after that.
- R6: With the hold configuration at 0, written via cfg_wr_i=1 with cfg_hold_i=0, done_o is 1 in the clock right after the strobe.
- R7: done_o is high for exactly one clock. In that clock busy_o is 0, ace_n_o is 1, sadb_o is 0 and sa_o carries the lowest address bits.
- R8: A start_i that arrives while busy_o is high is ignored. No further strobe occurs, and the address and mode of the active phase are unchanged, as seen on sa_o and sadb_o and in the lowest bits shown after done.
- R9: If beat_i is high in a clock where busy_o is low, the block captures addr_i and wide_i. In the next clock sa_o shows the new lowest bits, with ace_n_o=1, sadb_o=0 and busy_o=0. A beat_i that arrives while busy_o is high is ignored. If start_i and beat_i are both high, start_i wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a new address phase with a strobe |
| beat_i | input | 1 | Later burst beat: reload the address, no strobe |
| wide_i | input | 1 | Bus-width mode: 1 = 16-bit, 0 = 8-bit |
| addr_i | input | 29 | Byte address |
| cfg_wr_i | input | 1 | Write enable for the hold configuration bit |
| cfg_hold_i | input | 1 | New hold configuration value |
| sa_o | output | 6 | Dedicated address bus |
| sadb_o | output | 16 | Shared address/data bus (middle address during the phase, else 0) |
| ace_n_o | output | 1 | Active-low address latch strobe |
| done_o | output | 1 | One-clock pulse: the data phase may begin |
| busy_o | output | 1 | Strobe or hold clock in progress |

## Verification
The checker examines four properties on every clock. The strobe is a single clock that only ever follows an idle clock. done is a single-clock pulse that never overlaps busy. With hold enabled, the pins stay stable through the hold clock. With hold disabled, done follows the strobe directly. Some behaviour can only be shown by the bench's scenarios, with expected values computed from the byte address: the exact bit mapping in each width mode, the reset default of the hold bit, the dropping of start and beat requests during a busy phase, and the lower-bit updates for burst beats.

// File: rtl/aph_pkg.sv
package aph_pkg;
    parameter int ADDR_W = 29;
    parameter int SA_W   = 6;
    parameter int SADB_W = 16;
    // address bits covered by upper + middle + lower fields
    localparam int SPAN_W = 2 * SA_W + SADB_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_HOLD   = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SA_W-1:0]   upper;
        logic [SADB_W-1:0] middle;
        logic [SA_W-1:0]   lower;
    } addr_split_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wide;
    } req_t;

    // 16-bit mode drops the byte-select bit, 8-bit mode uses the address as is
    function automatic addr_split_t split_addr(input logic [ADDR_W-1:0] a,
                                               input logic wide);
        logic [ADDR_W-1:0] shifted;
        logic [SPAN_W-1:0] win;
        shifted = wide ? (a >> 1) : a;
        win     = shifted[SPAN_W-1:0];
        return addr_split_t'(win);
    endfunction
endpackage

// File: rtl/aph_capture.sv
module aph_capture
    import aph_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  req_t req_i,
    input  logic cfg_wr,
    input  logic cfg_hold,
    output req_t req_q,
    output logic hold_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            hold_q <= 1'b1;
        end else begin
            if (load)   req_q  <= req_i;
            if (cfg_wr) hold_q <= cfg_hold;
        end
    end
endmodule

// File: rtl/aph_fsm.sv
module aph_fsm
    import aph_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   hold,
    output phase_e phase,
    output logic   done,
    output logic   idle
);
    phase_e phase_d;
    logic   done_d;

    assign idle = (phase == PH_IDLE);

    always_comb begin
        phase_d = phase;
        done_d  = 1'b0;
        case (phase)
            PH_IDLE:   if (start) phase_d = PH_STROBE;
            PH_STROBE: begin
                if (hold) phase_d = PH_HOLD;
                else begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            PH_HOLD: begin
                phase_d = PH_IDLE;
                done_d  = 1'b1;
            end
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_d;
            done  <= done_d;
        end
    end
endmodule

// File: rtl/aph_addr_map.sv
module aph_addr_map
    import aph_pkg::*;
(
    input  req_t        req,
    output addr_split_t fields
);
    always_comb fields = split_addr(req.addr, req.wide);
endmodule

// File: rtl/addr_phase_gen.sv
module addr_phase_gen
    import aph_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              beat_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_hold_i,
    output logic [SA_W-1:0]   sa_o,
    output logic [SADB_W-1:0] sadb_o,
    output logic              ace_n_o,
    output logic              done_o,
    output logic              busy_o
);
    phase_e      phase;
    logic        idle;
    logic        cfg_hold_q;
    logic        accept_start;
    logic        load;
    req_t        req_in;
    req_t        req_q;
    addr_split_t fields;

    assign accept_start = start_i & idle;
    assign load         = (start_i | beat_i) & idle;
    assign req_in       = '{addr: addr_i, wide: wide_i};

    aph_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .req_i    (req_in),
        .cfg_wr   (cfg_wr_i),
        .cfg_hold (cfg_hold_i),
        .req_q    (req_q),
        .hold_q   (cfg_hold_q)
    );

    aph_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (accept_start),
        .hold  (cfg_hold_q),
        .phase (phase),
        .done  (done_o),
        .idle  (idle)
    );

    aph_addr_map u_map (
        .req    (req_q),
        .fields (fields)
    );

    always_comb begin
        ace_n_o = (phase != PH_STROBE);
        busy_o  = !idle;
        if (idle) begin
            sa_o   = fields.lower;
            sadb_o = '0;
        end else begin
            sa_o   = fields.upper;
            sadb_o = fields.middle;
        end
    end
endmodule

// File: rtl/aph_checker.sv
module aph_checker
    import aph_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ace_n,
    input logic              busy,
    input logic              done,
    input logic              hold,
    input logic [SA_W-1:0]   sa,
    input logic [SADB_W-1:0] sadb
);
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        !ace_n |=> ace_n);
    a_r2_strobe_busy: assert property (@(posedge clk) disable iff (rst)
        !ace_n |-> busy);
    a_r8_strobe_after_idle: assert property (@(posedge clk) disable iff (rst)
        !ace_n |-> $past(!busy));
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (!ace_n && hold) |=> (busy && !done && $stable(sa) && $stable(sadb)));
    a_r6_no_hold_done: assert property (@(posedge clk) disable iff (rst)
        (!ace_n && !hold) |=> done);
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && ace_n && sadb == '0));
    a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ace_n);
endmodule

bind addr_phase_gen aph_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .ace_n (ace_n_o),
    .busy  (busy_o),
    .done  (done_o),
    .hold  (cfg_hold_q),
    .sa    (sa_o),
    .sadb  (sadb_o)
);

// File: tb/sim_addr_phase_gen.sv
`timescale 1ns/1ps
module sim_addr_phase_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, beat_i = 1'b0, wide_i = 1'b0;
    logic [28:0] addr_i = '0;
    logic        cfg_wr_i = 1'b0, cfg_hold_i = 1'b0;
    logic [5:0]  sa_o;
    logic [15:0] sadb_o;
    logic        ace_n_o, done_o, busy_o;

    always #5 clk = ~clk;

    addr_phase_gen u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .beat_i(beat_i),
        .wide_i(wide_i), .addr_i(addr_i), .cfg_wr_i(cfg_wr_i),
        .cfg_hold_i(cfg_hold_i), .sa_o(sa_o), .sadb_o(sadb_o),
        .ace_n_o(ace_n_o), .done_o(done_o), .busy_o(busy_o)
    );

    typedef struct packed {
        logic [5:0]  sa;
        logic [15:0] sadb;
        logic        ace_n;
        logic        done;
        logic        busy;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0, n_bad = 0;
    bit    ended = 0;

    function automatic logic [5:0] f_upper(logic [28:0] a, logic w);
        return w ? a[28:23] : a[27:22];
    endfunction
    function automatic logic [15:0] f_middle(logic [28:0] a, logic w);
        return w ? a[22:7] : a[21:6];
    endfunction
    function automatic logic [5:0] f_lower(logic [28:0] a, logic w);
        return w ? a[6:1] : a[5:0];
    endfunction

    task automatic push(logic [5:0] sa, logic [15:0] sadb, logic ace_n,
                        logic done, logic busy, string tag);
        obs_t o;
        o.sa = sa; o.sadb = sadb; o.ace_n = ace_n; o.done = done; o.busy = busy;
        exp_q.push_back(o);
        tag_q.push_back(tag);
    endtask

    // monitor: one expected item per clock, sampled after the edge settles
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            obs_t  e;
            obs_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a.sa = sa_o; a.sadb = sadb_o; a.ace_n = ace_n_o; a.done = done_o; a.busy = busy_o;
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: actual sa=%h sadb=%h ace_n=%b done=%b busy=%b expected sa=%h sadb=%h ace_n=%b done=%b busy=%b",
                         t, a.sa, a.sadb, a.ace_n, a.done, a.busy,
                         e.sa, e.sadb, e.ace_n, e.done, e.busy);
            end
        end
    end

    // driver: one address phase; junk requests during the busy clocks if asked
    task automatic run_phase(logic [28:0] a, logic w, bit hold, bit junk,
                             logic [28:0] ja, string tag);
        @(negedge clk);
        addr_i = a; wide_i = w; start_i = 1'b1; beat_i = 1'b0;
        push(f_upper(a, w), f_middle(a, w), 1'b0, 1'b0, 1'b1, {tag, " strobe"});
        if (hold)
            push(f_upper(a, w), f_middle(a, w), 1'b1, 1'b0, 1'b1, {tag, " hold"});
        push(f_lower(a, w), 16'h0, 1'b1, 1'b1, 1'b0, {tag, " done"});
        @(negedge clk);
        if (junk) begin
            start_i = 1'b1; beat_i = 1'b1; addr_i = ja; wide_i = ~w;
        end else begin
            start_i = 1'b0;
        end
        if (hold) @(negedge clk);
        @(negedge clk);
        start_i = 1'b0; beat_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_beat(logic [28:0] a, logic w, string tag);
        @(negedge clk);
        beat_i = 1'b1; addr_i = a; wide_i = w;
        push(f_lower(a, w), 16'h0, 1'b1, 1'b0, 1'b0, tag);
        @(negedge clk);
        beat_i = 1'b0;
    endtask

    task automatic set_hold(logic h);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_hold_i = h;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        push(6'h0, 16'h0, 1'b1, 1'b0, 1'b0, "R1 reset");
        @(negedge clk);
        // R1 default hold, R3 16-bit mapping, R5 hold clock, R7 done
        run_phase(29'h1ABC_DE5B, 1'b1, 1, 0, '0, "R1 R3 R5 R7 wide");
        // R4 8-bit mapping with hold
        run_phase(29'h0F0F_33C7, 1'b0, 1, 0, '0, "R4 R5 narrow");
        // R6 no hold
        set_hold(1'b0);
        run_phase(29'h1555_AAAB, 1'b1, 0, 0, '0, "R6 R3 wide nohold");
        run_phase(29'h0AAA_5554, 1'b0, 0, 0, '0, "R6 R4 narrow nohold");
        run_phase(29'h1FFF_FFFF, 1'b1, 0, 0, '0, "R3 R7 all ones");
        // R8 / R9 ignored requests while busy, both hold settings
        run_phase(29'h0123_4567, 1'b1, 0, 1, 29'h1FED_CBA9, "R8 R9 busy ignore nohold");
        set_hold(1'b1);
        run_phase(29'h1357_9BDF, 1'b0, 1, 1, 29'h0246_8ACE, "R8 R9 busy ignore hold");
        // R9 burst beats without strobe
        do_beat(29'h1357_9BE3, 1'b0, "R9 beat narrow");
        do_beat(29'h1357_9BFE, 1'b1, "R9 beat wide");
        // R9 start wins over beat in the same clock
        @(negedge clk);
        start_i = 1'b1; beat_i = 1'b1; addr_i = 29'h0C3C_3C3D; wide_i = 1'b1;
        push(f_upper(29'h0C3C_3C3D, 1'b1), f_middle(29'h0C3C_3C3D, 1'b1), 1'b0, 1'b0, 1'b1, "R9 R2 start wins");
        @(negedge clk);
        start_i = 1'b0; beat_i = 1'b0;
        push(f_upper(29'h0C3C_3C3D, 1'b1), f_middle(29'h0C3C_3C3D, 1'b1), 1'b1, 1'b0, 1'b1, "R5 hold after start wins");
        push(f_lower(29'h0C3C_3C3D, 1'b1), 16'h0, 1'b1, 1'b1, 1'b0, "R7 done after start wins");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: actual %0d pending items expected 0", exp_q.size());
        end
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL R2: actual watchdog expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule